// File: doc/BRIEF.md
# Power-Down Clock Stopper

This block stops a bank of output clocks cleanly when the board asks the clock generator to enter its low-power state, and it starts them again when the request goes away. The request arrives on an active-low pin with no timing relation to any clock. It passes through a two-flop synchronizer into the CPU clock domain. It is acted on only after it has been seen LOW on two CPU rising edges in a row.

Every output has its own enable flop, clocked on the falling edge of that output's source clock. The enable can therefore change only while the source is LOW. A stopping clock always finishes its current HIGH phase and then parks LOW, and a restarting clock always begins with a complete HIGH phase. The enable flops report back through a synchronizer. Once all outputs are parked, the controller drops the PLL enable. On release, the controller raises the PLL enable first and waits a settle count of CPU cycles before reopening the outputs.

Output 0 is meant to be driven by the CPU clock itself. The other outputs carry the memory, 66 MHz, PCI and interrupt-controller clock groups. The enable flops assume that all source clocks come from one common VCO.

Top module: `pwrdn_clk_gate`

## Requirements
- R1: After reset, `pll_en_o` is 1 and every `gclk_o` bit follows its `src_clk_i` bit, so a full rising edge appears on each output in every source period.
- R2: A LOW on `req_n_i` that the CPU clock samples on only one rising edge has no effect: `pll_en_o` stays 1 and no output misses a pulse.
- R3: With `req_n_i` changed half-way between CPU rising edges, output 0 delivers exactly four more rising edges after the change and then stays LOW. This holds for a LOW lasting two CPU cycles as well as for a held LOW.
- R4: Every HIGH pulse on every output is as long as the HIGH phase of its source. Stopping and restarting never produce a runt pulse.
- R5: While the request stays LOW after the outputs have parked, every `gclk_o` bit stays LOW and `pll_en_o` stays 0.
- R6: `pll_en_o` goes to 0 only after every output has been parked LOW and its parked state has crossed into the CPU domain. At the moment it falls, all `gclk_o` bits are 0.
- R7: After the request returns HIGH, `pll_en_o` rises first. Output 0 shows its first rising edge on CPU rising edge number SETTLE_CYC+1 after the edge at which `pll_en_o` rose, which is 17 with the default value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU-domain clock that runs the controller |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n_i | input | 1 | Asynchronous active-low power-down request |
| src_clk_i | input | NUM_OUT | Free-running source clocks; bit 0 is the CPU clock |
| gclk_o | output | NUM_OUT | Gated copies of the source clocks |
| pll_en_o | output | 1 | PLL enable; 0 in the low-power state |

## Verification
A controller that leaves its running state too early or too late shifts the number of output-0 edges after a request away from four. The bench sees this within ten CPU cycles. An enable flop that changes while its source is HIGH leaves a short pulse at that output, and the bench measures the pulse at that output's next falling edge. A wrong parked acknowledgement or a wrong settle count shows up as `pll_en_o` falling while an output still toggles, or as the restart landing on an edge other than the seventeenth.

// File: rtl/pwrdn_pkg.sv
// Package: shared controller state encoding for the power-down clock stopper.
package pwrdn_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_STOP   = 3'd1,
        ST_PARK   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_WAKE   = 3'd4
    } pd_state_t;
endpackage

// File: rtl/pd_sync.sv
// Multi-stage flop synchronizer for a bundle of level signals.
// Assumes: each bit is a slow level, so bits need not stay coherent with each other.
module pd_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    // Shift the asynchronous input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= {WIDTH{RST_VAL}};
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pd_clk_gate.sv
// Glitch-free clock stopper for one output.
// The enable flop updates on the falling edge of its own source, so the enable
// changes only while the source is LOW. A stop therefore lands after a complete
// HIGH phase, and a restart begins with a complete HIGH phase.
// Assumes: gate_req_i comes from a clock that shares a VCO with clk_i.
module pd_clk_gate (
    input  logic clk_i,
    input  logic rst_n,
    input  logic gate_req_i,
    output logic clk_o,
    output logic parked_o
);
    logic en_q;

    // Take the run/stop request while the source is LOW.
    always_ff @(negedge clk_i) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= gate_req_i;
    end

    assign clk_o    = clk_i & en_q;
    assign parked_o = ~en_q;

    // R4: the enable drops only in response to a stop request.
    a_r4_stop_on_request: assert property (@(negedge clk_i) disable iff (!rst_n)
        $fell(en_q) |-> !$past(gate_req_i));
    // R4: the enable rises only in response to a run request.
    a_r4_run_on_request: assert property (@(negedge clk_i) disable iff (!rst_n)
        $rose(en_q) |-> $past(gate_req_i));
endmodule

// File: rtl/pd_ctrl.sv
// Power-down sequencer in the CPU clock domain.
// It qualifies the synchronized request over two rising edges, stops the outputs,
// waits for every output to report parked, and then drops the PLL enable.
// On release it raises the PLL enable, waits SETTLE_CYC cycles, and reopens the outputs.
// Assumes: req_n_s and parked_s are already synchronized to clk.
module pd_ctrl
    import pwrdn_pkg::*;
#(
    parameter int NUM_OUT    = 5,
    parameter int SETTLE_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_n_s,
    input  logic [NUM_OUT-1:0] parked_s,
    output logic               gate_req_o,
    output logic               pll_en_o
);
    localparam int               CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(SETTLE_CYC - 1);

    pd_state_t        state_q, state_d;
    logic             qual_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pd_hit;
    logic             all_parked;
    logic             all_running;

    // Keep the previous synchronized sample for the two-edge qualification.
    always_ff @(posedge clk) begin
        if (!rst_n) qual_q <= 1'b1;
        else        qual_q <= req_n_s;
    end

    assign pd_hit      = !req_n_s && !qual_q;
    assign all_parked  = &parked_s;
    assign all_running = ~|parked_s;

    // Choose the next sequencer state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (pd_hit)        state_d = ST_STOP;
            ST_STOP:   if (all_parked)    state_d = ST_PARK;
            ST_PARK:   if (req_n_s)       state_d = ST_SETTLE;
            ST_SETTLE: if (cnt_q == LAST) state_d = ST_WAKE;
            ST_WAKE:   if (all_running)   state_d = ST_RUN;
            default:                      state_d = ST_RUN;
        endcase
    end

    // Hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Count the PLL settle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q == ST_SETTLE) cnt_q <= cnt_q + 1'b1;
        else                         cnt_q <= '0;
    end

    assign gate_req_o = (state_q == ST_RUN) || (state_q == ST_WAKE);
    assign pll_en_o   = (state_q != ST_PARK);

    // R3: a stop follows only two LOW samples on consecutive edges.
    a_r3_two_low_edges: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_req_o) |-> (!$past(req_n_s, 1) && !$past(req_n_s, 2)));
    // R6: the PLL is off only while every output reports parked.
    a_r6_pll_off_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en_o |-> all_parked);
    // R7: outputs reopen only after a full settle count.
    a_r7_settle_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_req_o) |-> ($past(cnt_q) == LAST));
    // R7: the PLL enable is already high when outputs reopen.
    a_r7_pll_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_req_o) |-> $past(pll_en_o));
endmodule

// File: rtl/pwrdn_clk_gate.sv
// Top of the power-down clock stopper.
// It synchronizes the request, builds one glitch-free stopper per output, and
// sends each stopper's parked state back to the sequencer.
// Assumes: src_clk_i[0] is clk_cpu, and all sources share one VCO.
module pwrdn_clk_gate #(
    parameter int NUM_OUT    = 5,
    parameter int SETTLE_CYC = 16,
    parameter int SYNC_STG   = 2
) (
    input  logic               clk_cpu,
    input  logic               rst_n,
    input  logic               req_n_i,
    input  logic [NUM_OUT-1:0] src_clk_i,
    output logic [NUM_OUT-1:0] gclk_o,
    output logic               pll_en_o
);
    logic               req_n_s;
    logic               gate_req;
    logic [NUM_OUT-1:0] parked_raw;
    logic [NUM_OUT-1:0] parked_s;

    pd_sync #(.WIDTH(1), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_req_sync (
        .clk   (clk_cpu),
        .rst_n (rst_n),
        .d_i   (req_n_i),
        .q_o   (req_n_s)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        pd_clk_gate u_gate (
            .clk_i      (src_clk_i[g]),
            .rst_n      (rst_n),
            .gate_req_i (gate_req),
            .clk_o      (gclk_o[g]),
            .parked_o   (parked_raw[g])
        );
    end

    pd_sync #(.WIDTH(NUM_OUT), .STAGES(SYNC_STG), .RST_VAL(1'b0)) u_ack_sync (
        .clk   (clk_cpu),
        .rst_n (rst_n),
        .d_i   (parked_raw),
        .q_o   (parked_s)
    );

    pd_ctrl #(.NUM_OUT(NUM_OUT), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk        (clk_cpu),
        .rst_n      (rst_n),
        .req_n_s    (req_n_s),
        .parked_s   (parked_s),
        .gate_req_o (gate_req),
        .pll_en_o   (pll_en_o)
    );
endmodule

// File: tb/pwrdn_clk_gate_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, and monitors compare them against port observations.
module pwrdn_clk_gate_tb_top;
    localparam int N      = 5;
    localparam int SETTLE = 16;

    logic         clk_cpu = 1'b0;
    logic         c1 = 1'b0, c2 = 1'b0, c3 = 1'b0, c4 = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_n = 1'b1;
    logic [N-1:0] src;
    logic [N-1:0] gclk;
    logic         pll_en;

    int  errors = 0;
    int  checks = 0;
    bit  armed  = 0;
    int  rise_cnt [N];
    int  pll_falls = 0;
    string exp_tag_q [$];
    int    exp_val_q [$];

    always #2.5  clk_cpu = ~clk_cpu;
    always #3.75 c1 = ~c1;
    always #7.5  c2 = ~c2;
    always #15   c3 = ~c3;
    always #15   c4 = ~c4;
    assign src = {c4, c3, c2, c1, clk_cpu};

    pwrdn_clk_gate #(.NUM_OUT(N), .SETTLE_CYC(SETTLE)) dut_i (
        .clk_cpu   (clk_cpu),
        .rst_n     (rst_n),
        .req_n_i   (req_n),
        .src_clk_i (src),
        .gclk_o    (gclk),
        .pll_en_o  (pll_en)
    );

    function automatic real half_of(int g);
        case (g)
            0: return 2.5;
            1: return 3.75;
            2: return 7.5;
            default: return 15.0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver side: queue an expected value.
    task automatic push_exp(string tag, int v);
        exp_tag_q.push_back(tag);
        exp_val_q.push_back(v);
    endtask

    // Monitor side: compare an observation with the oldest expected value.
    task automatic observe(int act);
        string t;
        int    e;
        if (exp_val_q.size() == 0) begin
            check("scoreboard underflow", act, -1);
        end else begin
            t = exp_tag_q.pop_front();
            e = exp_val_q.pop_front();
            check(t, act, e);
        end
    endtask

    // Pulse monitor: counts rising edges and measures every HIGH width (R4).
    realtime t_rise [N];
    bit      have_rise [N];
    logic [N-1:0] prev = 'x;
    always @(gclk) begin
        for (int i = 0; i < N; i++) begin
            if (prev[i] !== 1'b1 && gclk[i] === 1'b1) begin
                rise_cnt[i]++;
                t_rise[i]    = $realtime;
                have_rise[i] = armed;
            end else if (prev[i] === 1'b1 && gclk[i] === 1'b0 && have_rise[i]) begin
                real w;
                w = $realtime - t_rise[i];
                checks++;
                if (w < half_of(i) - 0.01 || w > half_of(i) + 0.01) begin
                    errors++;
                    $display("FAIL R4 output %0d HIGH width: actual=%0f expected=%0f", i, w, half_of(i));
                end
            end
        end
        prev = gclk;
    end

    always @(negedge pll_en) if (armed) pll_falls++;

    // Count rises on every output over 60 ns and compare with full-rate counts.
    task automatic window_full(string tag);
        int snap [N];
        for (int i = 0; i < N; i++) snap[i] = rise_cnt[i];
        push_exp({tag, " out0 rises"}, 12);
        push_exp({tag, " out1 rises"}, 8);
        push_exp({tag, " out2 rises"}, 4);
        push_exp({tag, " out3 rises"}, 2);
        push_exp({tag, " out4 rises"}, 2);
        #60;
        for (int i = 0; i < N; i++) observe(rise_cnt[i] - snap[i]);
    endtask

    task automatic cpu_edges(int n);
        repeat (n) @(posedge clk_cpu);
        #1;
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int snap0;
        int n;
        for (int i = 0; i < N; i++) begin rise_cnt[i] = 0; have_rise[i] = 0; end
        repeat (6) @(posedge clk_cpu);
        #1 rst_n = 1'b1;
        cpu_edges(4);
        armed = 1;

        // R1: reset state and free-running outputs.
        push_exp("R1 pll_en after reset", 1);
        observe(int'(pll_en));
        cpu_edges(2);
        window_full("R1");

        // R2: LOW caught on a single rising edge is ignored.
        @(negedge clk_cpu) req_n = 1'b0;
        @(negedge clk_cpu) req_n = 1'b1;
        cpu_edges(2);
        window_full("R2");
        cpu_edges(10);
        push_exp("R2 pll_en falls", 0);
        observe(pll_falls);
        push_exp("R2 pll_en level", 1);
        observe(int'(pll_en));

        // R3: held request, output 0 gives four more edges.
        @(negedge clk_cpu) req_n = 1'b0;
        snap0 = rise_cnt[0];
        cpu_edges(10);
        push_exp("R3 out0 edges after held request", 4);
        observe(rise_cnt[0] - snap0);

        // R6: PLL drops only with every output LOW.
        wait (pll_en === 1'b0);
        #0.5;
        push_exp("R6 outputs at pll_en fall", 0);
        observe(int'(gclk));

        // R5: parked state holds while request stays LOW.
        snap0 = 0;
        for (int i = 0; i < N; i++) snap0 += rise_cnt[i];
        #300;
        n = 0;
        for (int i = 0; i < N; i++) n += rise_cnt[i];
        push_exp("R5 rises while parked", 0);
        observe(n - snap0);
        push_exp("R5 pll_en while parked", 0);
        observe(int'(pll_en));

        // R7: release, PLL first, then output 0 after the settle count.
        @(negedge clk_cpu) req_n = 1'b1;
        @(posedge pll_en);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(posedge clk_cpu);
            #1;
            n++;
            if (gclk[0] === 1'b1) break;
        end
        push_exp("R7 CPU edges from pll_en rise to out0 restart", SETTLE + 1);
        observe(n);
        push_exp("R7 pll_en at restart", 1);
        observe(int'(pll_en));
        cpu_edges(40);
        window_full("R7 after restart");

        // R3: a request two cycles long still stops after four edges.
        n = pll_falls;
        @(negedge clk_cpu) req_n = 1'b0;
        snap0 = rise_cnt[0];
        @(negedge clk_cpu);
        @(negedge clk_cpu) req_n = 1'b1;
        cpu_edges(9);
        push_exp("R3 out0 edges after two-cycle request", 4);
        observe(rise_cnt[0] - snap0);
        wait (pll_en === 1'b1 && pll_falls == n + 1);
        cpu_edges(60);
        push_exp("R6 pll_en fall count for two-cycle request", n + 1);
        observe(pll_falls);
        window_full("R4 after second restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule